// File: doc/BRIEF.md
# CAN Bus Low-Power Wakeup Controller

This block sits beside a CAN protocol engine and handles the power states of its bus interface. A two-bit mode select chooses run, CPU-wait, internal sleep or CPU-stop. The choice takes effect one clock later. In wait mode the interface stays fully active, and any enabled interrupt from the transmit, receive or error path raises a request that brings the CPU back. In stop mode the transmit pin is held recessive, whatever the engine drives, so that a halted clock cannot leave a dominant level on the bus.

In internal sleep the block watches the synchronised receive line for a dominant level and sets a wakeup flag when it sees one. An enable bit inserts a low-pass filter in front of that detector. With the filter on, the dominant level must last a set number of consecutive sampling clocks, so short bus glitches cannot wake the node. The flag is sticky and software clears it with a write-one-to-clear strobe.

Top module: `canWakeCtrl`

## Requirements
- R1: After reset, wakeFlag and cpuWake are 0, the mode is run, and txPin equals txEngine.
- R2: modeSel is encoded as 0 run, 1 wait, 2 sleep and 3 stop. A new value takes effect on the clock edge after it is applied.
- R3: In stop mode txPin is 1 (recessive) whatever txEngine is. In every other mode txPin equals txEngine.
- R4: In wait mode, cpuWake is 1 in the cycle after any bit of irqSrc & irqEn is set (bit 0 transmit, bit 1 receive, bit 2 error). Otherwise cpuWake is 0, and sources whose irqEn bit is 0 have no effect.
- R5: rxRaw passes through a two-flop synchroniser. A dominant level (0) applied before clock edge k can set wakeFlag no earlier than edge k+2.
- R6: In sleep with filtEn at 0, the first dominant sample sets wakeFlag.
- R7: In sleep with filtEn at 1, wakeFlag is set only after FILT_LEN consecutive dominant samples (default 8). A dominant level of FILT_LEN-1 samples does not set it.
- R8: With the filter on, any recessive sample restarts the dominant count from zero.
- R9: Wakeup detection is inactive in run, wait and stop modes, for either value of filtEn.
- R10: wakeFlag stays set until a wakeClr pulse clears it. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Requested power mode (0 run, 1 wait, 2 sleep, 3 stop) |
| filtEn | input | 1 | Enables the wakeup low-pass filter |
| rxRaw | input | 1 | Raw receive line, 0 means dominant |
| txEngine | input | 1 | Transmit bit from the protocol engine |
| irqSrc | input | 3 | Interrupt sources: transmit, receive, error |
| irqEn | input | 3 | Per-source interrupt enables |
| wakeClr | input | 1 | Write-one-to-clear strobe for wakeFlag |
| txPin | output | 1 | Transmit pin after the stop-mode override |
| wakeFlag | output | 1 | Sticky bus-activity wakeup flag |
| cpuWake | output | 1 | Request to bring the CPU out of wait |

## Verification
The hardest case to reach is a dominant level that stops just short of the filter length, together with a pattern that is broken by a single recessive sample. Either one only shows up as a flag that stays low. The stimulus table drives dominant pulses of exactly FILT_LEN-1 and FILT_LEN samples. It also drives two pulses that are each shorter than the filter length but together exceed it. Separate directed cases keep the line dominant while a clear strobe arrives, to show that a set wins over a clear in the same cycle.

// File: rtl/canWakePkg.sv
package canWakePkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_WAIT  = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_STOP  = 2'd3
  } pwrMode_t;

  typedef struct packed {
    logic sleepAct;
    logic filtOn;
    logic stopAct;
    logic waitAct;
  } wakeStrb_t;
endpackage

// File: rtl/canWakeCtl.sv
module canWakeCtl
  import canWakePkg::*;
#(
  parameter int IRQ_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             filtEn,
  input  logic [IRQ_W-1:0] irqSrc,
  input  logic [IRQ_W-1:0] irqEn,
  output wakeStrb_t        strb,
  output logic             cpuWake
);
  pwrMode_t modeQ;
  logic     anyIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_RUN;
    else       modeQ <= pwrMode_t'(modeSel);
  end

  always_comb begin
    strb.sleepAct = (modeQ == MODE_SLEEP);
    strb.stopAct  = (modeQ == MODE_STOP);
    strb.waitAct  = (modeQ == MODE_WAIT);
    strb.filtOn   = filtEn && (modeQ == MODE_SLEEP);
    anyIrq        = |(irqSrc & irqEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuWake <= 1'b0;
    else       cpuWake <= strb.waitAct && anyIrq;
  end
endmodule

// File: rtl/canWakeDp.sv
module canWakeDp
  import canWakePkg::*;
#(
  parameter int FILT_LEN = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  wakeStrb_t strb,
  input  logic      rxRaw,
  input  logic      txEngine,
  input  logic      wakeClr,
  output logic      rxSync,
  output logic      txPin,
  output logic      wakeFlag
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_LEN - 1);

  logic             rxMeta;
  logic [CNT_W-1:0] domCnt;
  logic             lenHit;
  logic             setWake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxRaw;
      rxSync <= rxMeta;
    end
  end

  assign lenHit = (domCnt == CNT_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          domCnt <= '0;
    else if (!strb.sleepAct || rxSync)  domCnt <= '0;
    else if (!lenHit)                   domCnt <= domCnt + 1'b1;
  end

  always_comb begin
    setWake = strb.sleepAct && !rxSync && (!strb.filtOn || lenHit);
    txPin   = strb.stopAct ? 1'b1 : txEngine;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeFlag <= 1'b0;
    else       wakeFlag <= setWake || (wakeFlag && !wakeClr);
  end
endmodule

// File: rtl/canWakeCtrl.sv
module canWakeCtrl
  import canWakePkg::*;
#(
  parameter int FILT_LEN = 8,
  parameter int IRQ_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             filtEn,
  input  logic             rxRaw,
  input  logic             txEngine,
  input  logic [IRQ_W-1:0] irqSrc,
  input  logic [IRQ_W-1:0] irqEn,
  input  logic             wakeClr,
  output logic             txPin,
  output logic             wakeFlag,
  output logic             cpuWake
);
  wakeStrb_t strb;
  logic      rxSync;

  canWakeCtl #(.IRQ_W(IRQ_W)) u_ctl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .filtEn(filtEn),
    .irqSrc(irqSrc), .irqEn(irqEn), .strb(strb), .cpuWake(cpuWake)
  );

  canWakeDp #(.FILT_LEN(FILT_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxRaw(rxRaw),
    .txEngine(txEngine), .wakeClr(wakeClr), .rxSync(rxSync),
    .txPin(txPin), .wakeFlag(wakeFlag)
  );
endmodule

// File: rtl/canWakeChk.sv
module canWakeChk
  import canWakePkg::*;
#(
  parameter int IRQ_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input wakeStrb_t        strb,
  input logic             rxSync,
  input logic             txEngine,
  input logic [IRQ_W-1:0] irqSrc,
  input logic [IRQ_W-1:0] irqEn,
  input logic             wakeClr,
  input logic             txPin,
  input logic             wakeFlag,
  input logic             cpuWake
);
  AST_STOP_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopAct |-> txPin); // R3
  AST_TX_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.stopAct |-> (txPin == txEngine)); // R3
  AST_WAIT_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.waitAct && |(irqSrc & irqEn)) |=> cpuWake); // R4
  AST_NO_WAKE_AWAY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.waitAct |=> !cpuWake); // R4
  AST_DETECT_SLEEP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (!wakeFlag && !strb.sleepAct) |=> !wakeFlag); // R9
  AST_RECESSIVE_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!wakeFlag && rxSync) |=> !wakeFlag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFlag && !wakeClr) |=> wakeFlag); // R10
  AST_UNFILT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sleepAct && !strb.filtOn && !rxSync) |=> wakeFlag); // R6
endmodule

bind canWakeCtrl canWakeChk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .rxSync(rxSync),
  .txEngine(txEngine), .irqSrc(irqSrc), .irqEn(irqEn),
  .wakeClr(wakeClr), .txPin(txPin), .wakeFlag(wakeFlag), .cpuWake(cpuWake)
);

// File: tb/canWakeCtrl_tb.sv
module canWakeCtrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FILT_LEN   = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic       filtEn = 1'b0;
  logic       rxRaw = 1'b1;
  logic       txEngine = 1'b0;
  logic [2:0] irqSrc = 3'b000;
  logic [2:0] irqEn = 3'b000;
  logic       wakeClr = 1'b0;
  logic       txPin, wakeFlag, cpuWake;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  canWakeCtrl #(.FILT_LEN(FILT_LEN)) u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .filtEn(filtEn),
    .rxRaw(rxRaw), .txEngine(txEngine), .irqSrc(irqSrc), .irqEn(irqEn),
    .wakeClr(wakeClr), .txPin(txPin), .wakeFlag(wakeFlag), .cpuWake(cpuWake)
  );

  // entry: {mode[1:0], filt, lowLen[7:0], expectFlag}
  localparam int NVEC = 9;
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd2, 1'b0, 8'd1,  1'b1},   // R6 single dominant sample
    {2'd2, 1'b1, 8'd7,  1'b0},   // R7 one short of the filter
    {2'd2, 1'b1, 8'd8,  1'b1},   // R7 exactly the filter length
    {2'd2, 1'b1, 8'd20, 1'b1},   // R7 long dominant
    {2'd2, 1'b0, 8'd0,  1'b0},   // R6 idle bus
    {2'd0, 1'b0, 8'd5,  1'b0},   // R9 run
    {2'd1, 1'b1, 8'd12, 1'b0},   // R9 wait
    {2'd3, 1'b0, 8'd5,  1'b0},   // R9 stop
    {2'd1, 1'b0, 8'd3,  1'b0}    // R9 wait unfiltered
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic clearFlag();
    modeSel = 2'd0; filtEn = 1'b0; rxRaw = 1'b1;
    wakeClr = 1'b1; tick(1); wakeClr = 1'b0; tick(1);
  endtask

  initial begin
    tick(3);
    check("R1 wakeFlag reset", wakeFlag, 1'b0);
    check("R1 cpuWake reset", cpuWake, 1'b0);
    txEngine = 1'b0; #1;
    check("R1 txPin follows engine", txPin, 1'b0);
    rstN = 1'b1;
    tick(2);

    for (int v = 0; v < NVEC; v++) begin
      modeSel = VEC[v][11:10]; filtEn = VEC[v][9];
      tick(2);
      for (int k = 0; k < int'(VEC[v][8:1]); k++) begin
        rxRaw = 1'b0; tick(1);
      end
      rxRaw = 1'b1;
      tick(4);
      check($sformatf("R7/R9 vector %0d wakeFlag", v), wakeFlag, VEC[v][0]);
      clearFlag();
    end

    // R5 synchroniser latency
    modeSel = 2'd2; filtEn = 1'b0; tick(2);
    rxRaw = 1'b0; tick(2);
    check("R5 no flag after two edges", wakeFlag, 1'b0);
    tick(1);
    check("R5 flag after third edge", wakeFlag, 1'b1);
    // R10 set wins over clear while dominant persists
    wakeClr = 1'b1; tick(1); wakeClr = 1'b0;
    check("R10 set beats clear", wakeFlag, 1'b1);
    rxRaw = 1'b1; tick(10);
    check("R10 flag held", wakeFlag, 1'b1);
    wakeClr = 1'b1; tick(1); wakeClr = 1'b0;
    check("R10 clear", wakeFlag, 1'b0);
    clearFlag();

    // R8 broken dominant pattern
    modeSel = 2'd2; filtEn = 1'b1; tick(2);
    rxRaw = 1'b0; tick(5); rxRaw = 1'b1; tick(1);
    rxRaw = 1'b0; tick(5); rxRaw = 1'b1; tick(4);
    check("R8 recessive restarts count", wakeFlag, 1'b0);
    clearFlag();

    // R2/R3 stop override and latency
    txEngine = 1'b0; modeSel = 2'd3; #1;
    check("R2 mode not yet applied", txPin, 1'b0);
    tick(1);
    check("R3 stop forces recessive", txPin, 1'b1);
    txEngine = 1'b1; #1;
    check("R3 stop with engine high", txPin, 1'b1);
    modeSel = 2'd0; txEngine = 1'b0; tick(1);
    check("R3 run passes engine", txPin, 1'b0);

    // R4 wait wake request
    modeSel = 2'd1; tick(1);
    irqEn = 3'b010; irqSrc = 3'b101; tick(1);
    check("R4 masked sources ignored", cpuWake, 1'b0);
    irqSrc = 3'b010; tick(1);
    check("R4 enabled rx irq wakes", cpuWake, 1'b1);
    irqEn = 3'b100; irqSrc = 3'b100; tick(1);
    check("R4 enabled error irq wakes", cpuWake, 1'b1);
    modeSel = 2'd0; tick(2);
    check("R4 no request in run", cpuWake, 1'b0);
    irqSrc = 3'b000; tick(1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule